// File: doc/BRIEF.md
# Ring Node Packet Receive Router

This block sits on the input link of one node of a unidirectional insertion ring. Each link symbol is a 16-bit word with one companion flag bit. The block finds packet boundaries from the flag alone: the flag rises on the first symbol of a packet and drops a fixed distance before the packet's last symbol (its check symbol). That distance depends on the packet kind. Short acknowledgement packets ("echoes") drop the flag one symbol before the end. Every other packet drops it four symbols before the end. No length field or delimiter is used.

The first symbol of a packet holds the destination node number. When it matches the node's own number (a static input), the whole packet is written into the receive queue, with start and end markers. Any other packet, and every idle symbol between packets, is forwarded unchanged toward the output link through the bypass stream. When a packet for this node starts while the receive queue reports full, the packet is discarded whole and a one-cycle busy pulse asks the sender to retry. The ring is never stalled for this reason.

Back-pressure: the input and the bypass output are valid/ready streams. A symbol moves on a cycle where valid and ready are both high. The input is ready whenever the single bypass output register is empty or is being drained that cycle. This holds for every symbol, including symbols bound for the receive queue. While the bypass output is valid and not ready, its data and flag stay frozen. The receive-queue port is a plain write strobe that cannot push back. Its full input is looked at only on the first symbol of a local packet.

Top module: `ring_rx_router`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `byp_valid`, `rxq_wr` and `busy_drop` are all low.
- R2: An accepted symbol with flag 1, whose previously accepted symbol had flag 0, starts a packet. If the low 16 bits of that first symbol equal `node_id` and `rxq_full` is low, every symbol of the packet is written to the receive queue in arrival order. `rxq_sop` is set on the first symbol only.
- R3: Symbols of packets for other nodes, and idle symbols (flag 0 outside any packet), appear on the bypass output in arrival order with data and flag unchanged. None of them is ever written to the receive queue.
- R4: For a standard packet, the final symbol is the fourth accepted symbol after the first flag-0 symbol of the packet. `rxq_eop` is set on that symbol only.
- R5: A packet is an echo when bit 15 of its second symbol is 1. For an echo, the final symbol is the accepted symbol right after the first flag-0 symbol.
- R6: The routing decision is taken from the first symbol alone and is held to the packet's end. Later symbols equal to `node_id`, or changes of `rxq_full`, do not change it.
- R7: If `rxq_full` is high when a local packet's first symbol is accepted, `busy_drop` pulses for one cycle. None of that packet's symbols reaches the receive queue or the bypass output.
- R8: `in_ready` is high exactly when `byp_valid` is low or `byp_ready` is high. While `byp_valid` is high and `byp_ready` is low, `byp_data` and `byp_flag` stay stable on the next cycle.
- R9: A symbol accepted in cycle n is presented on its output (bypass register or receive-queue write) in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 16 | This node's number, static |
| in_valid | input | 1 | Link symbol present |
| in_ready | output | 1 | Symbol can be taken this cycle |
| in_data | input | 16 | Link symbol |
| in_flag | input | 1 | Companion flag bit |
| byp_valid | output | 1 | Bypass symbol present |
| byp_ready | input | 1 | Bypass FIFO takes the symbol |
| byp_data | output | 16 | Forwarded symbol |
| byp_flag | output | 1 | Forwarded flag |
| rxq_wr | output | 1 | Receive-queue write strobe |
| rxq_data | output | 16 | Receive-queue symbol |
| rxq_sop | output | 1 | First symbol of packet |
| rxq_eop | output | 1 | Final symbol of packet |
| rxq_full | input | 1 | Receive queue cannot take a packet |
| busy_drop | output | 1 | Local packet discarded, retry needed |

## Verification
The bench uses the default parameters: 16-bit symbols and ids, a standard tail of 4, an echo tail of 1 and the echo marker in bit 15. It sweeps every combination of local and remote destination, echo and standard kind, one to four flag-high symbols, queue full or free, and zero to two idle symbols between packets. This covers back-to-back packets, a flag drop on the second symbol (where the kind bit and the fall coincide), and the drop path. Bypass back-pressure and input bubbles are driven from a pseudo-random sequence, so the hold and latency rules are met across stalls.

// File: rtl/ringrx_pkg.sv
package ringrx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HEAD, PH_TAIL} phase_t;
  typedef enum logic [1:0] {RT_PASS, RT_LOCAL, RT_DROP} route_t;
endpackage

// File: rtl/ringrx_framer.sv
module ringrx_framer
  import ringrx_pkg::*;
#(
  parameter int SYM_W     = 16,
  parameter int TAIL_STD  = 4,
  parameter int TAIL_ECHO = 1,
  parameter int ECHO_BIT  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             flag,
  input  logic [SYM_W-1:0] data,
  output logic             pkt_start,
  output logic             pkt_member,
  output logic             pkt_end
);
  localparam int TAIL_MAX = (TAIL_STD > TAIL_ECHO) ? TAIL_STD : TAIL_ECHO;
  localparam int CNT_W    = $clog2(TAIL_MAX + 1);

  phase_t           phase_q;
  logic             prev_flag_q;
  logic             second_q;
  logic             echo_q;
  logic [CNT_W-1:0] cnt_q;

  logic rise, fall, echo_now;

  always_comb begin
    rise       = flag & ~prev_flag_q;
    fall       = ~flag & (phase_q == PH_HEAD);
    echo_now   = second_q ? data[ECHO_BIT] : echo_q;
    pkt_start  = acc & rise;
    pkt_member = acc & (rise | (phase_q != PH_IDLE));
    pkt_end    = acc & ~rise & (phase_q == PH_TAIL) & (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      prev_flag_q <= 1'b0;
      second_q    <= 1'b0;
      echo_q      <= 1'b0;
      cnt_q       <= '0;
    end else if (acc) begin
      prev_flag_q <= flag;
      if (rise) begin
        phase_q  <= PH_HEAD;
        second_q <= 1'b1;
        echo_q   <= 1'b0;
      end else begin
        case (phase_q)
          PH_HEAD: begin
            second_q <= 1'b0;
            echo_q   <= echo_now;
            if (fall) begin
              phase_q <= PH_TAIL;
              cnt_q   <= echo_now ? CNT_W'(TAIL_ECHO) : CNT_W'(TAIL_STD);
            end
          end
          PH_TAIL: begin
            if (cnt_q == CNT_W'(1)) phase_q <= PH_IDLE;
            else                    cnt_q   <= cnt_q - CNT_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // R4: the tail countdown always stays within the longest tail.
  assert_tail_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TAIL) |-> (cnt_q != '0 && cnt_q <= CNT_W'(TAIL_MAX)));

  // R4: after the final symbol the framer is back between packets.
  assert_end_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/ringrx_route.sv
module ringrx_route
  import ringrx_pkg::*;
#(
  parameter int SYM_W = 16,
  parameter int ID_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic [SYM_W-1:0] data,
  input  logic [ID_W-1:0]  node_id,
  input  logic             rxq_full,
  output route_t           route,
  output logic             drop_now
);
  route_t route_q;
  route_t fresh;
  logic   hit;

  always_comb begin
    hit      = (data[ID_W-1:0] == node_id);
    fresh    = hit ? (rxq_full ? RT_DROP : RT_LOCAL) : RT_PASS;
    route    = pkt_start ? fresh : route_q;
    drop_now = pkt_start & hit & rxq_full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         route_q <= RT_PASS;
    else if (pkt_start) route_q <= fresh;
  end

  // R6: the decision only moves on a packet's first symbol.
  assert_route_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_start |=> $stable(route_q));
endmodule

// File: rtl/ringrx_outstage.sv
module ringrx_outstage
  import ringrx_pkg::*;
#(
  parameter int SYM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [SYM_W-1:0] data,
  input  logic             flag,
  input  logic             member,
  input  logic             start,
  input  logic             endp,
  input  route_t           route,
  input  logic             drop_now,
  input  logic             byp_ready,
  output logic             slot_free,
  output logic             byp_valid,
  output logic [SYM_W-1:0] byp_data,
  output logic             byp_flag,
  output logic             rxq_wr,
  output logic [SYM_W-1:0] rxq_data,
  output logic             rxq_sop,
  output logic             rxq_eop,
  output logic             drop_pulse
);
  logic to_byp, to_rxq;

  always_comb begin
    slot_free = ~byp_valid | byp_ready;
    to_byp    = acc & (~member | (route == RT_PASS));
    to_rxq    = acc & member & (route == RT_LOCAL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_valid <= 1'b0;
      byp_data  <= '0;
      byp_flag  <= 1'b0;
    end else if (to_byp) begin
      byp_valid <= 1'b1;
      byp_data  <= data;
      byp_flag  <= flag;
    end else if (byp_ready) begin
      byp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxq_wr     <= 1'b0;
      rxq_data   <= '0;
      rxq_sop    <= 1'b0;
      rxq_eop    <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      rxq_wr     <= to_rxq;
      rxq_data   <= data;
      rxq_sop    <= to_rxq & start;
      rxq_eop    <= to_rxq & endp;
      drop_pulse <= acc & drop_now;
    end
  end

  // R8: a stalled bypass symbol is held unchanged.
  assert_byp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_valid && !byp_ready) |=> (byp_valid && $stable(byp_data) && $stable(byp_flag)));

  // R7: a discarded packet never writes its first symbol.
  assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> !rxq_wr);

  // R9: every queue write comes from a symbol taken one cycle earlier.
  assert_rxq_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_wr |-> $past(acc));
endmodule

// File: rtl/ring_rx_router.sv
module ring_rx_router
  import ringrx_pkg::*;
#(
  parameter int SYM_W     = 16,
  parameter int ID_W      = 16,
  parameter int TAIL_STD  = 4,
  parameter int TAIL_ECHO = 1,
  parameter int ECHO_BIT  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  node_id,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_flag,
  output logic             byp_valid,
  input  logic             byp_ready,
  output logic [SYM_W-1:0] byp_data,
  output logic             byp_flag,
  output logic             rxq_wr,
  output logic [SYM_W-1:0] rxq_data,
  output logic             rxq_sop,
  output logic             rxq_eop,
  input  logic             rxq_full,
  output logic             busy_drop
);
  logic   acc, start, member, endp, drop_now, slot_free;
  route_t route;

  assign in_ready = slot_free;
  assign acc      = in_valid & slot_free;

  ringrx_framer #(
    .SYM_W(SYM_W), .TAIL_STD(TAIL_STD), .TAIL_ECHO(TAIL_ECHO), .ECHO_BIT(ECHO_BIT)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .acc(acc), .flag(in_flag), .data(in_data),
    .pkt_start(start), .pkt_member(member), .pkt_end(endp)
  );

  ringrx_route #(.SYM_W(SYM_W), .ID_W(ID_W)) u_route (
    .clk(clk), .rst_n(rst_n), .pkt_start(start), .data(in_data),
    .node_id(node_id), .rxq_full(rxq_full), .route(route), .drop_now(drop_now)
  );

  ringrx_outstage #(.SYM_W(SYM_W)) u_out (
    .clk(clk), .rst_n(rst_n), .acc(acc), .data(in_data), .flag(in_flag),
    .member(member), .start(start), .endp(endp), .route(route),
    .drop_now(drop_now), .byp_ready(byp_ready), .slot_free(slot_free),
    .byp_valid(byp_valid), .byp_data(byp_data), .byp_flag(byp_flag),
    .rxq_wr(rxq_wr), .rxq_data(rxq_data), .rxq_sop(rxq_sop), .rxq_eop(rxq_eop),
    .drop_pulse(busy_drop)
  );

  // R8: no symbol is taken while the bypass register is stalled.
  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_valid && !byp_ready) |-> !in_ready);
endmodule

// File: tb/ring_rx_router_tb.sv
module ring_rx_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 2048;
  localparam logic [15:0] NODE = 16'h0A5C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_flag = 1'b0, byp_ready = 1'b0, rxq_full = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, byp_valid, byp_flag, rxq_wr, rxq_sop, rxq_eop, busy_drop;
  logic [15:0] byp_data, rxq_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_rx_router u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(NODE),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_flag(in_flag),
    .byp_valid(byp_valid), .byp_ready(byp_ready), .byp_data(byp_data), .byp_flag(byp_flag),
    .rxq_wr(rxq_wr), .rxq_data(rxq_data), .rxq_sop(rxq_sop), .rxq_eop(rxq_eop),
    .rxq_full(rxq_full), .busy_drop(busy_drop)
  );

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] s_data [MAXS];
  logic        s_flag [MAXS];
  logic        s_full [MAXS];
  int          acc_cyc [MAXS];
  int          nsym = 0;

  logic [15:0] eb_data [MAXS];
  logic        eb_flag [MAXS];
  string       eb_req  [MAXS];
  int          nb = 0, rb = 0;

  logic [15:0] er_data [MAXS];
  logic        er_sop  [MAXS];
  logic        er_eop  [MAXS];
  string       er_req  [MAXS];
  int          er_sidx [MAXS];
  int          nr = 0, rr = 0;

  int exp_drops = 0, got_drops = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input logic f, input logic full,
                      input int dest, input bit sop, input bit eop, input string req);
    s_data[nsym] = d; s_flag[nsym] = f; s_full[nsym] = full;
    if (dest == 0) begin
      eb_data[nb] = d; eb_flag[nb] = f; eb_req[nb] = req; nb++;
    end else if (dest == 1) begin
      er_data[nr] = d; er_sop[nr] = sop; er_eop[nr] = eop; er_req[nr] = req;
      er_sidx[nr] = nsym; nr++;
    end
    nsym++;
  endtask

  task automatic build_pkt(input int p, input bit local_, input bit echo,
                           input int h, input bit full);
    int tl, total, dest;
    logic [15:0] d;
    string rq;
    tl = echo ? 1 : 4;
    total = h + tl + 1;
    dest = local_ ? (full ? 2 : 1) : 0;
    if (dest == 2) exp_drops++;
    for (int k = 0; k < total; k++) begin
      if (k == 0)                 d = local_ ? NODE : (NODE ^ 16'h0100);
      else if (k == 1)            d = {echo, 7'(p), 8'h01};
      else if (k == 2 && !local_) d = NODE;                   // R6 lookalike
      else                        d = {1'b0, 7'(p), 8'(k)};
      if (k == 0)                rq = "R2";
      else if (k == total - 1)   rq = echo ? "R5" : "R4";
      else if (k == 2 && !local_) rq = "R6";
      else                       rq = local_ ? "R2" : "R3";
      // after the first symbol a free queue claims full: decision must hold (R6)
      push(d, 1'(k < h), (k == 0) ? full : 1'b1, dest, k == 0, k == total - 1, rq);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    failures++; checks++;
    $display("FAIL R9 watchdog: cycles=%0d expected below %0d", cyc, 60000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic pv = 1'b0, pr = 1'b0, pf = 1'b0;
    logic [15:0] pd = '0;
    int idx = 0, drain = 0, p = 0;

    for (int loc = 0; loc < 2; loc++)
      for (int ec = 0; ec < 2; ec++)
        for (int h = 1; h <= 4; h++)
          for (int fu = 0; fu < 2; fu++)
            for (int g = 0; g < 3; g++) begin
              build_pkt(p, loc[0], ec[0], h, fu[0]);
              for (int i = 0; i < g; i++)
                push(16'h7000 | 16'(p * 4 + i), 1'b0, 1'b0, 0, 0, 0, "R3");
              p++;
            end

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!byp_valid && !rxq_wr && !busy_drop, "R1", "outputs in reset",
        {byp_valid, rxq_wr, busy_drop}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!byp_valid && !rxq_wr && !busy_drop, "R1", "outputs after reset",
        {byp_valid, rxq_wr, busy_drop}, 0);

    while (drain < 20) begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (idx < nsym) begin
        byp_ready = (lfsr[1:0] != 2'b00);
        in_valid  = (lfsr[4:2] != 3'b000);
        in_data   = s_data[idx];
        in_flag   = s_flag[idx];
        rxq_full  = s_full[idx];
      end else begin
        byp_ready = 1'b1; in_valid = 1'b0; drain++;
      end
      @(negedge clk);
      chk(in_ready == (!byp_valid || byp_ready), "R8", "in_ready",
          in_ready, !byp_valid || byp_ready);
      if (pv && !pr)
        chk(byp_valid && byp_data == pd && byp_flag == pf, "R8", "stalled bypass held",
            {byp_valid, byp_flag, byp_data}, {1'b1, pf, pd});
      pv = byp_valid; pr = byp_ready; pd = byp_data; pf = byp_flag;
      if (byp_valid && byp_ready) begin
        if (rb >= nb) chk(0, "R3", "unexpected bypass symbol", byp_data, 0);
        else begin
          chk(byp_data == eb_data[rb] && byp_flag == eb_flag[rb], eb_req[rb],
              "bypass symbol", {byp_flag, byp_data}, {eb_flag[rb], eb_data[rb]});
          rb++;
        end
      end
      if (rxq_wr) begin
        if (rr >= nr) chk(0, "R3", "unexpected queue write", rxq_data, 0);
        else begin
          chk(rxq_data == er_data[rr] && rxq_sop == er_sop[rr] && rxq_eop == er_eop[rr],
              er_req[rr], "queue symbol", {rxq_sop, rxq_eop, rxq_data},
              {er_sop[rr], er_eop[rr], er_data[rr]});
          chk(cyc == acc_cyc[er_sidx[rr]] + 1, "R9", "queue write latency",
              cyc, acc_cyc[er_sidx[rr]] + 1);
          rr++;
        end
      end
      if (busy_drop) got_drops++;
      if (in_valid && in_ready && idx < nsym) begin
        acc_cyc[idx] = cyc;
        idx++;
      end
    end

    chk(rb == nb, "R3", "bypass symbols delivered", rb, nb);
    chk(rr == nr, "R2", "queue symbols written", rr, nr);
    chk(got_drops == exp_drops, "R7", "discard pulses", got_drops, exp_drops);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule